// File: doc/BRIEF.md
# Stereo Overload Detector with Hold

This block watches the two channels of a stereo sample stream as it leaves a decimation path. Each channel arrives as a signed 20-bit parallel word, and both words are qualified by one sample-valid strobe. When the saturated magnitude of either word is above a fixed level, the block raises a single overload flag. That level is seven eighths of full scale, roughly 1.16 dB below the largest digital swing.

Once raised, the flag stays up for a minimum number of sample periods, so that a slow controller or an indicator lamp can still see a short clip. Every further overload reloads the hold timer to its full value. The timer advances only on sample strobes, so the hold length is counted in sample periods and does not depend on the clock rate. Clock cycles without a strobe change nothing.

Top module: `ovl_stereo_detect`

## Requirements
- R1: While reset is asserted, and on the first sample period after it, the flag is 0; reset clears the hold timer.
- R2: A strobed left sample whose saturated magnitude is above 458752 sets the flag high from the clock edge that captures that strobe.
- R3: A strobed right sample whose saturated magnitude is above 458752 sets the flag high from the clock edge that captures that strobe.
- R4: The comparison is strict. A magnitude of exactly 458752 (the codes +458752 and -458752) is not an overload, while the codes +458753 and -458753 are overloads.
- R5: The most negative code, -524288 (hex 80000), saturates to magnitude 524287 and counts as an overload.
- R6: Samples presented while the strobe is low are ignored: out-of-range values without a strobe leave the flag low.
- R7: After an overload with no further overload, the flag stays high through the next HOLD_SAMPLES-1 strobed clean samples (512 by default) and goes low at the edge of the HOLD_SAMPLES-th clean strobe.
- R8: An overload on any strobe while the flag is high reloads the hold timer, so the flag goes low only at the HOLD_SAMPLES-th clean strobe after the most recent overload. This includes an overload on the strobe that would otherwise have cleared the flag.
- R9: Clock cycles without a strobe neither shorten nor extend the hold; any number of idle cycles leaves the flag and the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_left | input | 20 | Left channel sample, two's complement |
| smp_right | input | 20 | Right channel sample, two's complement |
| smp_vld | input | 1 | Both samples are valid in this cycle |
| ovl_flag | output | 1 | Overload flag with retriggerable hold |

## Verification
Two functions can fall in the same cycle: the reload of the hold timer after a fresh overload, and the expiry that clears the flag. The bench provokes this by sending an overload on exactly the HOLD_SAMPLES-th clean strobe after an earlier one. It then judges that the flag did not fall at that edge, and that the full hold was counted again from that point. A second overlap, with both channels over the threshold on one strobe, is checked to behave like a single overload.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int SMP_W   = 20;
    localparam int FS_POS  = 2 ** (SMP_W - 1);
    localparam int MAG_MAX = FS_POS - 1;
    // seven eighths of full scale, about 1.16 dB down
    localparam int OVL_THR = FS_POS - (FS_POS / 8);
    localparam int N_CHAN  = 2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic        [SMP_W-1:0] mag_t;

    typedef struct packed {
        logic over;
        mag_t mag;
    } chan_eval_t;

    function automatic mag_t sat_mag(input smp_t x);
        mag_t r;
        if (!x[SMP_W-1])
            r = mag_t'(x);
        else if (x == smp_t'(FS_POS))
            r = mag_t'(MAG_MAX);
        else
            r = mag_t'(-x);
        return r;
    endfunction
endpackage

// File: rtl/ovl_mag.sv
module ovl_mag
    import ovl_pkg::*;
(
    input  smp_t       smp,
    output chan_eval_t res
);
    always_comb begin
        res.mag  = sat_mag(smp);
        res.over = (res.mag > mag_t'(OVL_THR));
    end

    // R5
    always_comb begin
        sat_range_chk: assert (res.mag <= mag_t'(MAG_MAX));
    end
endmodule

// File: rtl/ovl_hold.sv
module ovl_hold #(
    parameter int HOLD_SAMPLES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic hit,
    output logic flag
);
    localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_SAMPLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            cnt  <= '0;
        end else if (vld) begin
            if (hit) begin
                flag <= 1'b1;
                cnt  <= RELOAD;
            end else if (cnt != '0) begin
                cnt  <= cnt - 1'b1;
            end else begin
                flag <= 1'b0;
            end
        end
    end

    // R2
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && hit) |=> flag);

    // R6
    rise_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(vld && hit));

    // R7
    no_early_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && cnt != '0) |=> flag);

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> ($stable(flag) && $stable(cnt)));
endmodule

// File: rtl/ovl_stereo_detect.sv
module ovl_stereo_detect
    import ovl_pkg::*;
#(
    parameter int HOLD_SAMPLES = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    input  logic             smp_vld,
    output logic             ovl_flag
);
    smp_t                    chan_smp [N_CHAN];
    chan_eval_t              chan_res [N_CHAN];
    logic       [N_CHAN-1:0] chan_over;
    logic                    any_over;

    assign chan_smp[0] = smp_t'(smp_left);
    assign chan_smp[1] = smp_t'(smp_right);

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        ovl_mag u_mag (
            .smp (chan_smp[c]),
            .res (chan_res[c])
        );
        assign chan_over[c] = chan_res[c].over;
    end

    assign any_over = |chan_over;

    ovl_hold #(
        .HOLD_SAMPLES(HOLD_SAMPLES)
    ) u_hold (
        .clk  (clk),
        .rst  (rst),
        .vld  (smp_vld),
        .hit  (any_over),
        .flag (ovl_flag)
    );
endmodule

// File: tb/sim_ovl_stereo_detect.sv
module sim_ovl_stereo_detect;
    localparam int HOLD = 512;
    localparam int W    = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] smp_left  = '0;
    logic [W-1:0] smp_right = '0;
    logic         smp_vld   = 1'b0;
    logic         ovl_flag;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    ovl_stereo_detect #(.HOLD_SAMPLES(HOLD)) u0 (
        .clk       (clk),
        .rst       (rst),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .smp_vld   (smp_vld),
        .ovl_flag  (ovl_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: ovl_flag=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b0; smp_left = '0; smp_right = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one strobed sample, then one idle cycle; returns at a falling edge
    task automatic strobe(input int l, input int r);
        @(negedge clk);
        smp_left = W'(l); smp_right = W'(r); smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0; smp_left = '0; smp_right = '0;
    endtask

    task automatic clean(input int n);
        for (int i = 0; i < n; i++) strobe(1000, -1000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 during reset", ovl_flag, 1'b0);
        do_reset();
        clean(1);
        check("R1 after reset", ovl_flag, 1'b0);
    endtask

    task automatic t_left();
        do_reset();
        strobe(500000, 0);
        check("R2 left positive over", ovl_flag, 1'b1);
        do_reset();
        strobe(-500000, 0);
        check("R2 left negative over", ovl_flag, 1'b1);
    endtask

    task automatic t_right();
        do_reset();
        strobe(0, 470000);
        check("R3 right positive over", ovl_flag, 1'b1);
        do_reset();
        strobe(500000, 500000);
        check("R3 both channels over", ovl_flag, 1'b1);
    endtask

    task automatic t_bounds();
        do_reset();
        strobe(458752, -458752);
        check("R4 exactly at threshold", ovl_flag, 1'b0);
        strobe(-458752, 458752);
        check("R4 threshold swapped", ovl_flag, 1'b0);
        strobe(458753, 0);
        check("R4 one above threshold", ovl_flag, 1'b1);
        do_reset();
        strobe(0, -458753);
        check("R4 one below negative threshold", ovl_flag, 1'b1);
    endtask

    task automatic t_minneg();
        do_reset();
        strobe(-524288, 0);
        check("R5 most negative left", ovl_flag, 1'b1);
        do_reset();
        strobe(0, -524288);
        check("R5 most negative right", ovl_flag, 1'b1);
    endtask

    task automatic t_novld();
        do_reset();
        @(negedge clk);
        smp_left = W'(-524288); smp_right = W'(500000);
        for (int i = 0; i < 20; i++) @(negedge clk);
        check("R6 unstrobed overload ignored", ovl_flag, 1'b0);
        smp_left = '0; smp_right = '0;
        clean(2);
        check("R6 clean strobes after", ovl_flag, 1'b0);
    endtask

    task automatic t_hold();
        do_reset();
        strobe(500000, 0);
        clean(HOLD - 1);
        check("R7 held through HOLD-1 clean", ovl_flag, 1'b1);
        clean(1);
        check("R7 drops at HOLD-th clean", ovl_flag, 1'b0);
    endtask

    task automatic t_retrig_mid();
        do_reset();
        strobe(500000, 0);
        clean(100);
        strobe(0, -500000);
        clean(HOLD - 1);
        check("R8 mid-hold retrigger holds", ovl_flag, 1'b1);
        clean(1);
        check("R8 mid-hold retrigger drops", ovl_flag, 1'b0);
    endtask

    task automatic t_retrig_edge();
        do_reset();
        strobe(0, 500000);
        clean(HOLD - 1);
        strobe(-524288, 0);
        check("R8 retrigger on expiry strobe", ovl_flag, 1'b1);
        clean(HOLD - 1);
        check("R8 full hold recounted", ovl_flag, 1'b1);
        clean(1);
        check("R8 drops after recount", ovl_flag, 1'b0);
    endtask

    task automatic t_idle();
        do_reset();
        strobe(500000, 0);
        for (int i = 0; i < 3000; i++) @(negedge clk);
        check("R9 idle cycles keep flag", ovl_flag, 1'b1);
        clean(HOLD - 1);
        check("R9 idle did not shorten hold", ovl_flag, 1'b1);
        clean(1);
        check("R9 idle did not extend hold", ovl_flag, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_left();
        t_right();
        t_bounds();
        t_minneg();
        t_novld();
        t_hold();
        t_retrig_mid();
        t_retrig_edge();
        t_idle();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule